// File: doc/BRIEF.md
# Data Cache Controller with Stale-Index Recovery

This block is the control state machine of a set-associative data cache whose tag and data arrays return their read one cycle after the index is presented. The array index comes from one of two owners: the load/store pipeline or a page-table walker. Each cycle the controller picks the array index, qualifies the raw tag compare into a hit or a miss, and drives a cache-enable strobe. That strobe commits a store and advances the controller's own history registers. It also raises a stall toward the pipeline. A miss is handed off through a fill request and a fill-done handshake. Line fill and writeback sequencing live outside the block.

Because array reads are registered, the hit seen in a cycle belongs to the index launched one cycle earlier. When the walker hands the arrays back to the pipeline, that earlier index may still be the walker's index. The controller detects this case and stalls for one cycle. During that cycle it re-reads at the pipeline's own index, so the next hit is trustworthy. A store hit that arrives while the pipeline is stalled is also allowed to commit, but only in the first stalled cycle.

Top module: `dcache_ctrl`

## Requirements
- R1: After reset the controller is in the access state, the index history and the walker-select history hold zero, and the stalled-cycle history holds zero. With no request the outputs hit_o, miss_o, stall_o and fill_req_o are all 0.
- R2: The array index selection follows this priority:
  - When walk_sel_i is 1, sram_idx_o equals walk_idx_i.
  - Otherwise, when stall_i or stall_o is 1, sram_idx_o equals addr_idx_i.
  - Otherwise, sram_idx_o equals next_idx_i.
- R3: In the access state with a request (req_rw_i bit 1 = read, bit 0 = write, either nonzero), hit_o equals tag_hit_i. In that state miss_o equals the inverse of tag_hit_i, except that flush_i set to 1 forces miss_o to 0. Outside a stale cycle the two outputs are never both 1.
- R4: A stale cycle occurs when the walker-select history is 1, walk_sel_i is 0, and the index history differs from addr_idx_i. In a stale cycle:
  - hit_o and miss_o are 0.
  - stall_o is 1 for exactly that one cycle.
  - sram_idx_o equals addr_idx_i.
  - On the next cycle, hit_o follows tag_hit_i again.
- R5: When walk_sel_i falls and the index history equals addr_idx_i, no stall is raised and the hit is reported in the same cycle.
- R6: An index history that differs from addr_idx_i never causes a stall on its own, without a falling walk_sel_i.
- R7: The index history and the walker-select history load sram_idx_o and walk_sel_i only in cycles where cache_en_o is 1.
- R8: cache_en_o is 1 whenever stall_i is 0 or stall_o is 1, and is 0 for a stalled cycle that carries no first-stall store commit.
- R9: A write that hits in the access state, with stall_o at 0, while stall_i is 1, drives cache_en_o to 1 only when stall_i was 0 in the previous cycle. It stays 0 for the later cycles of the same stall.
- R10: The commit of R9 is withheld when st_fault_i or flush_i is 1.
- R11: A miss moves the controller to the fetch state. While in that state, fill_req_o and stall_o are 1 and hit_o and miss_o are 0. The controller stays there until fill_done_i is 1 and is back in the access state on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_idx_i | input | IDX_W | Set index of the access currently owning the pipeline slot |
| next_idx_i | input | IDX_W | Set index of the upcoming access, launched when not stalled |
| walk_idx_i | input | IDX_W | Set index requested by the page walker |
| walk_sel_i | input | 1 | Walker owns the arrays this cycle |
| req_rw_i | input | 2 | Request: bit 1 read, bit 0 write |
| tag_hit_i | input | 1 | Raw tag compare from the registered array read |
| stall_i | input | 1 | Pipeline stall |
| st_fault_i | input | 1 | Store/AMO page fault on the current access |
| flush_i | input | 1 | Flush of the current access |
| fill_done_i | input | 1 | Line fill complete |
| sram_idx_o | output | IDX_W | Index launched into the tag and data arrays |
| cache_en_o | output | 1 | Commit and history-update enable |
| hit_o | output | 1 | Qualified hit |
| miss_o | output | 1 | Qualified miss |
| stall_o | output | 1 | Controller stall request |
| fill_req_o | output | 1 | Line fill in progress |

## Verification
Several input patterns are applied.

- Plain read hits with distinct current and next indices separate the launch index from the current index. They also show that an index mismatch alone is harmless.
- Walker hand-backs are applied both with an index that differs from the current one and with an index that matches it. The differing case shows the one-cycle re-read; the matching case shows that no extra stall is added.
- A walker grant that occurs only inside an external stall shows that the history is gated by the enable.
- Store hits under stalls of several cycles, with and without a fault or flush, show that the commit happens once and is blocked when it should be.
- A miss with a multi-cycle fill exercises the fetch wait.

// File: rtl/dcache_ctrl_pkg.sv
package dcache_ctrl_pkg;
  typedef enum logic {
    ST_ACCESS = 1'b0,
    ST_FETCH  = 1'b1
  } dcc_state_e;

  localparam int unsigned RW_WR_BIT = 0;
  localparam int unsigned RW_RD_BIT = 1;
endpackage

// File: rtl/dcc_idx_hist.sv
module dcc_idx_hist #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             walk_i,
  input  logic [IDX_W-1:0] addr_idx_i,
  output logic             stale_o
);
  logic [IDX_W-1:0] prev_idx_q;
  logic             prev_walk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_idx_q  <= '0;
      prev_walk_q <= 1'b0;
    end else if (en_i) begin
      prev_idx_q  <= idx_i;
      prev_walk_q <= walk_i;
    end
  end

  // array output still belongs to the walker's index
  assign stale_o = prev_walk_q & ~walk_i & (prev_idx_q != addr_idx_i);

  a_r7_hist_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(prev_idx_q) && $stable(prev_walk_q));

  a_r4_stale_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stale_o && en_i) |=> !stale_o);
endmodule

// File: rtl/dcc_store_commit.sv
module dcc_store_commit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stall_i,
  input  logic wr_hit_i,
  input  logic block_i,
  output logic first_o
);
  logic was_stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) was_stall_q <= 1'b0;
    else         was_stall_q <= stall_i;
  end

  assign first_o = wr_hit_i & stall_i & ~was_stall_q & ~block_i;

  a_r9_single_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_o && stall_i) |=> !first_o);
endmodule

// File: rtl/dcc_fsm.sv
module dcc_fsm
  import dcache_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic tag_hit_i,
  input  logic stale_i,
  input  logic flush_i,
  input  logic fill_done_i,
  output logic hit_o,
  output logic miss_o,
  output logic busy_o,
  output logic in_access_o,
  output logic fill_req_o
);
  dcc_state_e state_q, state_d;

  assign in_access_o = (state_q == ST_ACCESS);
  assign hit_o       = in_access_o & req_i & tag_hit_i & ~stale_i;
  assign miss_o      = in_access_o & req_i & ~tag_hit_i & ~stale_i & ~flush_i;
  assign fill_req_o  = (state_q == ST_FETCH);
  assign busy_o      = miss_o | fill_req_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACCESS: if (miss_o) state_d = ST_FETCH;
      ST_FETCH:  if (fill_done_i) state_d = ST_ACCESS;
      default:   state_d = ST_ACCESS;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ACCESS;
    else         state_q <= state_d;
  end

  a_r11_fill_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_done_i) |=> fill_req_o);

  a_r11_fill_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && fill_done_i) |=> in_access_o);
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_ctrl_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] addr_idx_i,
  input  logic [IDX_W-1:0] next_idx_i,
  input  logic [IDX_W-1:0] walk_idx_i,
  input  logic             walk_sel_i,
  input  logic [1:0]       req_rw_i,
  input  logic             tag_hit_i,
  input  logic             stall_i,
  input  logic             st_fault_i,
  input  logic             flush_i,
  input  logic             fill_done_i,
  output logic [IDX_W-1:0] sram_idx_o,
  output logic             cache_en_o,
  output logic             hit_o,
  output logic             miss_o,
  output logic             stall_o,
  output logic             fill_req_o
);
  logic stale, fsm_busy, in_access, first_st, req_any, wr_hit;

  assign req_any = |req_rw_i;

  dcc_idx_hist #(.IDX_W(IDX_W)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cache_en_o),
    .idx_i      (sram_idx_o),
    .walk_i     (walk_sel_i),
    .addr_idx_i (addr_idx_i),
    .stale_o    (stale)
  );

  dcc_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_any),
    .tag_hit_i   (tag_hit_i),
    .stale_i     (stale),
    .flush_i     (flush_i),
    .fill_done_i (fill_done_i),
    .hit_o       (hit_o),
    .miss_o      (miss_o),
    .busy_o      (fsm_busy),
    .in_access_o (in_access),
    .fill_req_o  (fill_req_o)
  );

  assign stall_o = stale | fsm_busy;
  assign wr_hit  = in_access & req_rw_i[RW_WR_BIT] & tag_hit_i & ~stall_o;

  dcc_store_commit u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stall_i  (stall_i),
    .wr_hit_i (wr_hit),
    .block_i  (st_fault_i | flush_i),
    .first_o  (first_st)
  );

  // stale re-read and stalls hold the array on the current access
  always_comb begin
    if (walk_sel_i)             sram_idx_o = walk_idx_i;
    else if (stall_i | stall_o) sram_idx_o = addr_idx_i;
    else                        sram_idx_o = next_idx_i;
  end

  assign cache_en_o = ~stall_i | stall_o | first_st;

  a_r4_reread_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stale |-> (sram_idx_o == addr_idx_i) && !hit_o && !miss_o);

  a_r10_commit_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !stall_o && (st_fault_i || flush_i)) |-> !cache_en_o);

  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));
endmodule

// File: tb/sim_dcache_ctrl.sv
module sim_dcache_ctrl;
  localparam int IDX_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [IDX_W-1:0] addr_idx = '0, next_idx = '0, walk_idx = '0;
  logic             walk_sel = 0, tag_hit = 0, stall = 0, fault = 0, flush = 0, fill_done = 0;
  logic [1:0]       req = '0;
  logic [IDX_W-1:0] sram_idx;
  logic             cache_en, hit, miss, stall_o, fill_req;

  int checks = 0, errors = 0;

  // behavioural reference state
  int m_prev_idx = 0;
  bit m_prev_walk = 0, m_fetch = 0, m_was_stall = 0;

  always #5 clk = ~clk;

  dcache_ctrl #(.IDX_W(IDX_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_idx_i(addr_idx), .next_idx_i(next_idx),
    .walk_idx_i(walk_idx), .walk_sel_i(walk_sel), .req_rw_i(req), .tag_hit_i(tag_hit),
    .stall_i(stall), .st_fault_i(fault), .flush_i(flush), .fill_done_i(fill_done),
    .sram_idx_o(sram_idx), .cache_en_o(cache_en), .hit_o(hit), .miss_o(miss),
    .stall_o(stall_o), .fill_req_o(fill_req)
  );

  task automatic cmp(input string tag, input string sig, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", tag, sig, got, exp, $time);
    end
  endtask

  // called just after a falling edge with inputs driven
  task automatic step(input string tag);
    bit stl, e_hit, e_miss, e_stall, e_first, e_en;
    int e_idx;
    #4;
    stl     = m_prev_walk && !walk_sel && (m_prev_idx != int'(addr_idx));
    e_hit   = !m_fetch && (req != 0) && tag_hit && !stl;
    e_miss  = !m_fetch && (req != 0) && !tag_hit && !stl && !flush;
    e_stall = stl || e_miss || m_fetch;
    e_first = !m_fetch && req[0] && tag_hit && !e_stall && stall && !m_was_stall && !fault && !flush;
    e_en    = !stall || e_stall || e_first;
    if (walk_sel) e_idx = int'(walk_idx);
    else if (stall || e_stall) e_idx = int'(addr_idx);
    else e_idx = int'(next_idx);
    cmp(tag, "sram_idx", int'(sram_idx), e_idx);
    cmp(tag, "cache_en", int'(cache_en), int'(e_en));
    cmp(tag, "hit", int'(hit), int'(e_hit));
    cmp(tag, "miss", int'(miss), int'(e_miss));
    cmp(tag, "stall", int'(stall_o), int'(e_stall));
    cmp(tag, "fill_req", int'(fill_req), int'(m_fetch));
    @(posedge clk);
    if (e_en) begin
      m_prev_idx  = e_idx;
      m_prev_walk = walk_sel;
    end
    m_was_stall = stall;
    if (!m_fetch && e_miss) m_fetch = 1;
    else if (m_fetch && fill_done) m_fetch = 0;
    @(negedge clk);
  endtask

  task automatic idle();
    walk_sel = 0; req = 0; tag_hit = 0; stall = 0; fault = 0; flush = 0; fill_done = 0;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    step("R1"); step("R1");

    // R2 R3 R8 plain read hits, launch index vs current index
    req = 2'b10; tag_hit = 1; addr_idx = 3; next_idx = 4; step("R3");
    addr_idx = 4; next_idx = 7; step("R2");
    stall = 1; step("R8");
    stall = 0; addr_idx = 7; next_idx = 9; step("R8");
    // R3 flush kills a miss
    tag_hit = 0; flush = 1; step("R3");
    idle();

    // R6 index mismatch without walker edge
    req = 2'b10; tag_hit = 1;
    for (int i = 0; i < 4; i++) begin
      addr_idx = 6'(10 + i); next_idx = 6'(30 + i); step("R6");
    end

    // R11 miss and fill
    addr_idx = 12; next_idx = 13; tag_hit = 0; step("R11");
    for (int i = 0; i < 3; i++) step("R11");
    fill_done = 1; step("R11");
    fill_done = 0; tag_hit = 1; step("R11");
    idle();

    // R4 walker hand-back at a different index
    walk_sel = 1; walk_idx = 33; step("R4"); step("R4");
    walk_sel = 0; addr_idx = 40; next_idx = 41; req = 2'b10; tag_hit = 1; step("R4");
    step("R4");
    idle();

    // R5 hand-back at the same index
    walk_sel = 1; walk_idx = 40; step("R5");
    walk_sel = 0; addr_idx = 40; next_idx = 44; req = 2'b10; tag_hit = 1; step("R5");
    idle();

    // R7 walker grant only inside an external stall
    step("R7");
    stall = 1; walk_sel = 1; walk_idx = 50; step("R7");
    stall = 0; walk_sel = 0; addr_idx = 51; next_idx = 52; req = 2'b10; tag_hit = 1; step("R7");
    idle();

    // R9 stalled store hit commits once
    req = 2'b01; tag_hit = 1; addr_idx = 5; next_idx = 6; step("R9");
    stall = 1; step("R9"); step("R9"); step("R9");
    stall = 0; step("R9");

    // R10 fault or flush withholds the commit
    stall = 1; fault = 1; step("R10"); step("R10");
    stall = 0; fault = 0; step("R10");
    stall = 1; flush = 1; step("R10");
    stall = 0; flush = 0; step("R10");
    idle(); step("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule